// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, inside one multiprocessor, which resident warp gets the next instruction issue slot. It tracks 24 warp slots of 32 threads each. An issue slot lasts four processor cycles because only eight processing lanes exist. In each of those four cycles the block names the issued warp, the index of the eight-thread lane group that is active, and a strobe for each lane. Every thread of the issued warp runs the same instruction; only its register data differs.

A new warp is chosen only on the boundary between slots. The choice is a round-robin search over the warps that are valid, ready and not waiting on memory. The search starts just after the warp issued last. A warp whose issued instruction is a memory read is parked, so other warps fill the slots while the read is outstanding. A completion pulse tagged with the warp number releases the parked warp. Completion pulses may arrive on any cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held and after it is released, `issue_idle` is 1, `lane_strobe` is all zeros and `lane_group` is 3. All parked flags are clear, and the round-robin pointer is at warp 0, so the first slot with every warp eligible issues warp 0.
- R2: A warp is chosen only at the clock edge that ends a slot, and the first such edge is the first edge after reset is released. `issue_warp`, `issue_idle` and `issue_read` hold their values for all four cycles of the slot, whatever the inputs do during it.
- R3: `lane_group` steps 0, 1, 2, 3 through each slot. `slot_first` is 1 exactly when `lane_group` is 0.
- R4: In a slot where a warp was issued, `lane_strobe` is all ones in each of its four cycles.
- R5: A warp is eligible only when its bit is set in both `warp_valid` and `warp_ready` and the warp is not parked.
- R6: The search for an eligible warp starts at the index one above the last issued warp and wraps from 23 to 0.
- R7: If the chosen warp has its `warp_mem_rd` bit set, `issue_read` is 1 for that slot and the warp is parked. A parked warp is not chosen until a completion for it is seen.
- R8: A pulse on `mem_done` in any cycle clears the parked flag of warp `mem_done_id`. A tag of 24 or above has no effect.
- R9: A completion that arrives at the same edge as the read issue for the same warp is applied after that issue, so the warp ends unparked.
- R10: When no warp is eligible at a slot boundary, `issue_idle` is 1 and `lane_strobe` is 0 for the four cycles, and the round-robin pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | 24 | Warp slot holds a resident warp, one bit per warp |
| warp_ready | input | 24 | Warp has its next instruction ready to issue |
| warp_mem_rd | input | 24 | Warp's next instruction is a memory read |
| mem_done | input | 1 | Read completion pulse |
| mem_done_id | input | 5 | Warp number of the completed read |
| issue_warp | output | 5 | Warp issued in the current slot |
| issue_idle | output | 1 | No warp was issued in the current slot |
| issue_read | output | 1 | The issued instruction is a memory read |
| lane_group | output | 2 | Which eight-thread group of the warp is active this cycle |
| slot_first | output | 1 | First cycle of an issue slot |
| lane_strobe | output | 8 | Per-lane active strobe |

## Verification
Read issue and read completion can fall on the same clock edge, and both can name the same warp. The bench provokes this by holding `mem_done` with the chosen warp's tag across the selection edge of a slot in which that warp issues a read. It judges the result at the ports: the next slot, with only that warp ready, must issue the warp rather than going idle. A completion that lands in the middle of a slot is also driven, and so is one with an out-of-range tag. Each is judged by whether the parked warp is issued again in the following slot.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Index one step forward on a ring of n entries.
  function automatic int ring_inc(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Index offset steps forward from base on a ring of n entries.
  function automatic int ring_add(input int base, input int offset, input int n);
    int s;
    s = base + offset;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb #(
  parameter int N = 24,
  parameter int W = 5
) (
  input  logic [N-1:0] elig,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] pick
);
  import wsched_pkg::*;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = ring_add(int'(ptr), k, N);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = W'(idx);
      end
    end
  end

endmodule

// File: rtl/wsched_park.sv
module wsched_park #(
  parameter int N = 24,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_id,
  input  logic         clr_en,
  input  logic [W-1:0] clr_id,
  output logic [N-1:0] park_q
);

  logic [N-1:0] park_d;

  always_comb begin
    park_d = park_q;
    // issue is applied first, completion second (R9)
    if (set_en && int'(set_id) < N) park_d[set_id] = 1'b1;
    if (clr_en && int'(clr_id) < N) park_d[clr_id] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) park_q <= '0;
    else        park_q <= park_d;
  end

  p_read_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_id == set_id)) |=> park_q[$past(set_id)]);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && int'(clr_id) < N) |=> !park_q[$past(clr_id)]);

  p_same_edge_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_en && clr_id == set_id) |=> !park_q[$past(set_id)]);

endmodule

// File: rtl/wsched_slot.sv
module wsched_slot #(
  parameter int GROUPS = 4,
  parameter int GW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [GW-1:0] phase,
  output logic          pick_now,
  output logic          first
);

  localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= LAST;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign pick_now = (phase == LAST);
  assign first    = (phase == '0);

  p_phase_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != LAST) |=> (phase == $past(phase) + 1'b1));

  p_phase_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == '0));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int WARP_THREADS = 32,
  parameter int NUM_LANES    = 8,
  localparam int GROUPS      = WARP_THREADS / NUM_LANES,
  localparam int WID_W       = $clog2(NUM_WARPS),
  localparam int GRP_W       = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_valid,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_mem_rd,
  input  logic                 mem_done,
  input  logic [WID_W-1:0]     mem_done_id,
  output logic [WID_W-1:0]     issue_warp,
  output logic                 issue_idle,
  output logic                 issue_read,
  output logic [GRP_W-1:0]     lane_group,
  output logic                 slot_first,
  output logic [NUM_LANES-1:0] lane_strobe
);
  import wsched_pkg::*;

  logic [NUM_WARPS-1:0] park_q;
  logic [NUM_WARPS-1:0] elig;
  logic [WID_W-1:0]     rr_ptr;
  logic [WID_W-1:0]     win;
  logic                 win_found;
  logic                 pick_now;
  logic                 fire_issue;
  logic                 fire_read;
  logic [GRP_W-1:0]     phase;

  wsched_slot #(.GROUPS(GROUPS), .GW(GRP_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pick_now(pick_now), .first(slot_first)
  );

  assign elig = warp_valid & warp_ready & ~park_q;

  wsched_rr_arb #(.N(NUM_WARPS), .W(WID_W)) u_arb (
    .elig(elig), .ptr(rr_ptr), .found(win_found), .pick(win)
  );

  assign fire_issue = pick_now && win_found;
  assign fire_read  = fire_issue && warp_mem_rd[win];

  wsched_park #(.N(NUM_WARPS), .W(WID_W)) u_park (
    .clk(clk), .rst_n(rst_n),
    .set_en(fire_read), .set_id(win),
    .clr_en(mem_done), .clr_id(mem_done_id),
    .park_q(park_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr     <= '0;
      issue_warp <= '0;
      issue_idle <= 1'b1;
      issue_read <= 1'b0;
    end else if (pick_now) begin
      issue_idle <= !win_found;
      issue_read <= fire_read;
      if (win_found) begin
        issue_warp <= win;
        rr_ptr     <= WID_W'(ring_inc(int'(win), NUM_WARPS));
      end
    end
  end

  assign lane_group  = phase;
  assign lane_strobe = issue_idle ? '0 : '1;

  p_pick_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_issue |-> (warp_valid[win] && warp_ready[win] && !park_q[win]));

  p_hold_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_now |=> ($stable(issue_warp) && $stable(issue_idle) && $stable(issue_read)));

  p_idle_keeps_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_now && !win_found) |=> (issue_idle && $stable(rr_ptr)));

  p_idle_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_idle |-> (lane_strobe == '0));

  p_read_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_read |-> !issue_idle);

endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
  localparam int NW = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NW-1:0] warp_valid, warp_ready, warp_mem_rd;
  logic        mem_done;
  logic [4:0]  mem_done_id;
  logic [4:0]  issue_warp;
  logic        issue_idle, issue_read, slot_first;
  logic [1:0]  lane_group;
  logic [7:0]  lane_strobe;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  warp_issue_sched dut (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_ready(warp_ready),
    .warp_mem_rd(warp_mem_rd), .mem_done(mem_done), .mem_done_id(mem_done_id),
    .issue_warp(issue_warp), .issue_idle(issue_idle), .issue_read(issue_read),
    .lane_group(lane_group), .slot_first(slot_first), .lane_strobe(lane_strobe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Run one slot from the negedge before a slot boundary; returns at the
  // negedge of the slot's last cycle. exp_warp < 0 means an idle slot.
  task automatic run_slot(input string req, input logic [NW-1:0] v, input logic [NW-1:0] r,
                          input logic [NW-1:0] rd, input int exp_warp, input int exp_read,
                          input int edge_done, input int mid_done);
    warp_valid = v; warp_ready = r; warp_mem_rd = rd;
    if (edge_done >= 0) begin mem_done = 1'b1; mem_done_id = 5'(edge_done); end
    @(posedge clk); @(negedge clk);
    mem_done = 1'b0;
    chk({req, " group0"}, int'(lane_group), 0);
    chk({"R3 first"}, int'(slot_first), 1);
    chk({req, " idle"}, int'(issue_idle), exp_warp < 0);
    if (exp_warp >= 0) begin
      chk({req, " warp"}, int'(issue_warp), exp_warp);
      chk({"R4 strobe"}, int'(lane_strobe), 255);
      chk({"R7 read flag"}, int'(issue_read), exp_read);
    end else chk({"R10 strobe"}, int'(lane_strobe), 0);
    // inputs change mid-slot; slot outputs must hold (R2)
    warp_valid = '1; warp_ready = '1; warp_mem_rd = '0;
    for (int g = 1; g < 4; g++) begin
      if (g == 1 && mid_done >= 0) begin mem_done = 1'b1; mem_done_id = 5'(mid_done); end
      @(negedge clk);
      mem_done = 1'b0;
      chk("R3 group", int'(lane_group), g);
      chk("R3 first low", int'(slot_first), 0);
      chk("R2 hold idle", int'(issue_idle), exp_warp < 0);
      if (exp_warp >= 0) chk("R2 hold warp", int'(issue_warp), exp_warp);
    end
  endtask

  localparam int NV = 9;
  localparam logic [NW-1:0] TV_V[NV] = '{24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF,
                                          24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h800000, 24'hFFFFFF};
  localparam logic [NW-1:0] TV_R[NV] = '{24'hFFFFFF, 24'h100020, 24'h100020, 24'h400008,
                                          24'h000004, 24'hFFFFFF, 24'hFFFFFF, 24'h800000, 24'hFFFFFF};
  localparam int TV_EXP[NV] = '{0, 5, 20, 22, 2, -1, 3, 23, 0};

  initial begin
    rst_n = 1'b0; warp_valid = '0; warp_ready = '0; warp_mem_rd = '0;
    mem_done = 1'b0; mem_done_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 idle in reset", int'(issue_idle), 1);
    chk("R1 strobe in reset", int'(lane_strobe), 0);
    chk("R1 group in reset", int'(lane_group), 3);
    rst_n = 1'b1;

    // R5 R6 R10: table of eligibility patterns walked by one loop
    for (int i = 0; i < NV; i++)
      run_slot(i == 0 ? "R1 first pick" : (TV_EXP[i] < 0 ? "R10 none" : "R6 rr"),
               TV_V[i], TV_R[i], '0, TV_EXP[i], 0, -1, -1);
    // pointer now 1. R5: ready but not valid is skipped
    run_slot("R5 valid mask", 24'h000010, 24'h000012, '0, 4, 0, -1, -1);

    // R7 park, R8 mid-slot release
    run_slot("R7 read issue", 24'h000080, 24'h000080, 24'h000080, 7, 1, -1, -1);
    run_slot("R7 parked", 24'h000080, 24'h000080, '0, -1, 0, -1, 7);
    run_slot("R8 released", 24'h000080, 24'h000080, '0, 7, 0, -1, -1);

    // R8 out-of-range tag ignored
    run_slot("R7 read issue 9", 24'h000200, 24'h000200, 24'h000200, 9, 1, -1, 30);
    run_slot("R8 bad tag ignored", 24'h000200, 24'h000200, '0, -1, 0, -1, 9);
    run_slot("R8 release 9", 24'h000200, 24'h000200, '0, 9, 0, -1, -1);

    // R9 issue and completion on the same edge for warp 11
    run_slot("R9 read issue 11", 24'h000800, 24'h000800, 24'h000800, 11, 1, 11, -1);
    run_slot("R9 not parked", 24'h000800, 24'h000800, '0, 11, 0, -1, -1);

    // R1 reset mid-run: pointer back to 0, park flags cleared
    run_slot("R7 park 12", 24'h001000, 24'h001000, 24'h001000, 12, 1, -1, -1);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 idle after reset", int'(issue_idle), 1);
    chk("R1 group after reset", int'(lane_group), 3);
    rst_n = 1'b1;
    run_slot("R1 ptr zero", '1, '1, '0, 0, 0, -1, -1);
    run_slot("R1 park cleared", 24'h001000, 24'h001000, '0, 12, 0, -1, -1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule